// File: doc/BRIEF.md
# Shared-DAC Successive Approximation Controller

This block runs an 8-bit successive-approximation conversion on a DAC that also serves as the analog output. A start pulse opens a conversion. The controller first strobes the input sample. It then holds the analog output through a track-and-hold control, so the DAC can be borrowed for the conversion. Next it drives trial codes from the most significant bit down to the least significant bit. Each trial code stays on the DAC for a programmable number of settling cycles, and then the external comparator is sampled.

After the last bit is decided, the DAC multiplexer returns to the user's output code while the hold is still engaged. On the following cycle the hold is released, the result register is written and a one-cycle done pulse is issued. A channel sequencer can use that pulse to advance. A conversion taken from a differential channel is stored as two's complement. A single-ended conversion is stored as plain binary. The comparator and the DAC are outside the block.

Top module: `sar_shared_dac`

## Requirements
- R1: After reset the result register reads 0x80. The busy, hold, sample, done and DAC-select outputs are low, and the DAC code follows the user code.
- R2: A start seen in idle gives, in the next cycle, a one-cycle sample strobe. Hold and busy are high in that cycle, and the DAC still shows the user code.
- R3: The trial phase follows the sample cycle. It has 8 steps of SETTLE cycles each, with DAC-select high. The first step drives 0x80. At the last cycle of each step, the tested bit is kept only if the comparator input is 1. The next lower bit is then set for the following step.
- R4: After the last bit decision there is one restore cycle. In that cycle DAC-select is low and the DAC shows the user code, while hold is still high.
- R5: The done pulse is high for exactly one cycle, 8*SETTLE+2 cycles after the start edge. In that same cycle busy and hold are low.
- R6: For a single-ended conversion (diff low at start), the result is the plain binary SAR code.
- R7: For a differential conversion (diff high at start), the result is the SAR code with its most significant bit inverted. This gives two's complement of the offset-binary code.
- R8: The result register changes only in the cycle where done is high.
- R9: A start pulse that arrives while busy is ignored. Done timing and the result are unaffected, and no further conversion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion start pulse |
| diff_i | input | 1 | Selected channel is differential (captured at start) |
| user_code_i | input | 8 | Analog output code from the data register |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the DAC level |
| dac_code_o | output | 8 | Code driven to the shared DAC |
| dac_sel_o | output | 1 | 1 when the DAC carries a trial code |
| hold_o | output | 1 | Track-and-hold control for the analog output |
| sample_o | output | 1 | Input sample strobe |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle conversion complete pulse |
| result_o | output | 8 | Conversion result register |

## Verification
Call the edge that captures start E0. The sample strobe is due one cycle after E0, and the first trial code (0x80) one cycle after that. The step after the first trial is due SETTLE cycles later. The restore cycle is due 8*SETTLE+1 cycles after E0, and done with the new result 8*SETTLE+2 cycles after E0. The bench changes inputs on falling edges and counts rising edges from E0 before each sample, so every output is read in the exact cycle it is due. The comparator is modelled as an ideal comparison of a fixed input level against the DAC code, so the expected result is the level itself, or the level with its top bit inverted for differential channels.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAMPLE  = 2'd1,
        ST_CONV    = 2'd2,
        ST_RESTORE = 2'd3
    } sar_state_e;
endpackage

// File: rtl/sar_step_timer.sv
module sar_step_timer #(
    parameter int SETTLE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic last_o
);
    localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        last_o = run_i && (cnt_q == CW'(SETTLE - 1));
        if (!run_i || last_o) cnt_d = '0;
        else                  cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3
    step_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CW'(SETTLE - 1)) |=> (cnt_q == '0));
endmodule

// File: rtl/sar_result_enc.sv
module sar_result_enc #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] code_i,
    input  logic             diff_i,
    output logic [WIDTH-1:0] result_o
);
    always_comb begin
        result_o = code_i;
        if (diff_i) result_o[WIDTH-1] = ~code_i[WIDTH-1];
    end
endmodule

// File: rtl/sar_shared_dac.sv
module sar_shared_dac
    import sar_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int SETTLE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             diff_i,
    input  logic [WIDTH-1:0] user_code_i,
    input  logic             cmp_i,
    output logic [WIDTH-1:0] dac_code_o,
    output logic             dac_sel_o,
    output logic             hold_o,
    output logic             sample_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] result_o
);
    localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [WIDTH-1:0] MID_CODE = WIDTH'(1) << (WIDTH - 1);

    typedef struct packed {
        sar_state_e       st;
        logic [IW-1:0]    bidx;
        logic [WIDTH-1:0] trial;
        logic [WIDTH-1:0] result;
        logic             diff;
        logic             done;
    } sar_regs_t;

    sar_regs_t q, d;
    logic step_last;
    logic [WIDTH-1:0] enc_result;

    sar_step_timer #(.SETTLE(SETTLE)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (q.st == ST_CONV),
        .last_o (step_last)
    );

    sar_result_enc #(.WIDTH(WIDTH)) u_enc (
        .code_i   (q.trial),
        .diff_i   (q.diff),
        .result_o (enc_result)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st   = ST_SAMPLE;
                    d.diff = diff_i;
                end
            end
            ST_SAMPLE: begin
                d.st    = ST_CONV;
                d.trial = MID_CODE;
                d.bidx  = IW'(WIDTH - 1);
            end
            ST_CONV: begin
                if (step_last) begin
                    if (!cmp_i) d.trial[q.bidx] = 1'b0;
                    if (q.bidx == '0) begin
                        d.st = ST_RESTORE;
                    end else begin
                        d.bidx = q.bidx - IW'(1);
                        d.trial[q.bidx - IW'(1)] = 1'b1;
                    end
                end
            end
            ST_RESTORE: begin
                d.st     = ST_IDLE;
                d.done   = 1'b1;
                d.result = enc_result;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st     <= ST_IDLE;
            q.bidx   <= '0;
            q.trial  <= '0;
            q.result <= MID_CODE;
            q.diff   <= 1'b0;
            q.done   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign dac_sel_o  = (q.st == ST_CONV);
    assign dac_code_o = dac_sel_o ? q.trial : user_code_i;
    assign hold_o     = (q.st != ST_IDLE);
    assign sample_o   = (q.st == ST_SAMPLE);
    assign busy_o     = (q.st != ST_IDLE);
    assign done_o     = q.done;
    assign result_o   = q.result;

    // R4
    trial_under_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sel_o |-> hold_o);
    // R4
    restore_before_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_sel_o) |-> hold_o);
    // R2
    sample_then_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |=> (dac_sel_o && dac_code_o == MID_CODE));
    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R5
    done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!hold_o && !busy_o));
    // R8
    result_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));
    // R9
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_sel_o && start_i) |=> !sample_o);
endmodule

// File: tb/sar_shared_dac_test.sv
module sar_shared_dac_test;
    localparam int W = 8;
    localparam int S = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         diff_i = 1'b0;
    logic [W-1:0] user_code_i = 8'h3C;
    logic [W-1:0] vin = 8'h00;
    logic         cmp_i;
    logic [W-1:0] dac_code_o;
    logic         dac_sel_o, hold_o, sample_o, busy_o, done_o;
    logic [W-1:0] result_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    assign cmp_i = (vin >= dac_code_o);

    sar_shared_dac #(.WIDTH(W), .SETTLE(S)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .diff_i(diff_i),
        .user_code_i(user_code_i), .cmp_i(cmp_i), .dac_code_o(dac_code_o),
        .dac_sel_o(dac_sel_o), .hold_o(hold_o), .sample_o(sample_o),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    // R1
    task automatic t_reset();
        chk("R1", "result", result_o, 8'h80);
        chk("R1", "busy/hold/sample/done/sel",
            {busy_o, hold_o, sample_o, done_o, dac_sel_o}, 0);
        chk("R1", "dac follows user", dac_code_o, user_code_i);
    endtask

    // R2 R3 R4 R5 R6 R7 R8 (and R9 when poke is set)
    task automatic t_convert(input logic [W-1:0] v, input logic dif,
                             input logic [W-1:0] exp, input logic poke);
        logic [W-1:0] prev;
        prev = result_o;
        vin = v; diff_i = dif; start_i = 1'b1;
        tick(1);
        start_i = 1'b0; diff_i = ~dif;
        chk("R2", "sample/hold/busy/sel", {sample_o, hold_o, busy_o, dac_sel_o}, 4'b1110);
        chk("R2", "dac user during sample", dac_code_o, user_code_i);
        tick(1);
        chk("R3", "first trial", dac_code_o, 8'h80);
        chk("R3", "sel in trial", {dac_sel_o, sample_o}, 2'b10);
        tick(S);
        chk("R3", "second trial", dac_code_o, {v[7], 7'h40});
        if (poke) begin
            start_i = 1'b1;
            tick(1);
            start_i = 1'b0;
            chk("R9", "no resample while busy", sample_o, 0);
            tick(7 * S - 1);
        end else begin
            tick(7 * S);
        end
        chk("R4", "restore sel/hold", {dac_sel_o, hold_o}, 2'b01);
        chk("R4", "restore user code", dac_code_o, user_code_i);
        chk("R8", "result unchanged before done", result_o, prev);
        chk("R5", "no early done", done_o, 0);
        tick(1);
        chk("R5", "done/busy/hold", {done_o, busy_o, hold_o}, 3'b100);
        chk(dif ? "R7" : "R6", "result", result_o, exp);
        tick(1);
        chk("R5", "done one cycle", done_o, 0);
        tick(3);
        chk("R9", "idle after conversion", {busy_o, sample_o}, 0);
        chk("R8", "result held", result_o, exp);
    endtask

    initial begin
        fork
            begin
                tick(3);
                rst_n = 1'b1;
                tick(1);
                t_reset();
                t_convert(8'hA5, 1'b0, 8'hA5, 1'b0);
                t_convert(8'h00, 1'b0, 8'h00, 1'b0);
                t_convert(8'hFF, 1'b0, 8'hFF, 1'b0);
                t_convert(8'h40, 1'b0, 8'h40, 1'b0);
                t_convert(8'h80, 1'b1, 8'h00, 1'b0);
                t_convert(8'h10, 1'b1, 8'h90, 1'b0);
                t_convert(8'hFF, 1'b1, 8'h7F, 1'b0);
                t_convert(8'h5A, 1'b0, 8'h5A, 1'b1);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule